// File: doc/BRIEF.md
# Linearity Test Stimulus Sequencer

This block generates the code stream for a high-resolution DAC that drives an analog-to-digital converter under a linearity test. The ramp steps are finer than the converter's LSB, so each converter code collects many samples. A downstream histogram can then yield differential and integral nonlinearity. With each DAC code the block issues a sample strobe that marks the cycle in which the converter output is to be captured. A second flag marks captures that are perturbation samples, so the histogram can drop them.

There are three stimulus profiles. The first is a plain rising staircase. The second is a staircase in which a programmable dark or bright level briefly replaces the settle phase of a step. That level is never sampled, which imitates the reset peak of an image-sensor pixel. The third is a staircase in which the perturbation level becomes a sample of its own, which imitates a dark pixel followed by a bright one. The full-scale sweep repeats a programmed number of times. A one-cycle done pulse then ends the run.

The run is configured through the mode, repeat count, perturbation period and perturbation level inputs. These are captured when start is accepted.

Top module: `rampStimSeq`

## Requirements
- R1: Out of reset and while idle, dacCode is 0 and sampleStrobe, pertSample and seqDone are all 0. A start pulse seen while idle launches a run, and the first run cycle follows the accepting clock edge.
- R2: Every sample period lasts two cycles. A ramp step holds its code for both cycles, and sampleStrobe is high only in the second cycle. Within a sweep the ramp codes run 0, 1, ..., 2^DAC_W-1, and each code is sampled exactly once.
- R3: The number of sweeps equals repeatCount, with 0 treated as 1. Between sweeps the ramp wraps from all-ones back to 0.
- R4: In perturbated mode (testMode = 1), each time pertPeriod ramp steps have been sampled, the first cycle of the next ramp step shows pertLevel without a strobe. The step count carries across sweeps. pertSample stays 0 in this mode.
- R5: In alternated mode (testMode = 2), each time pertPeriod ramp steps have been sampled, an extra two-cycle period is inserted before the next ramp step. It shows pertLevel in both cycles, with sampleStrobe and pertSample both high in its second cycle.
- R6: A pertPeriod of 0 disables perturbation. No perturbation follows the final ramp step of the final sweep.
- R7: testMode = 0 (quasi-static) and the unused code testMode = 3 produce the plain staircase with no perturbation.
- R8: seqDone is a single-cycle pulse in the cycle right after the last strobe. In that cycle dacCode is already back to 0.
- R9: Mode, repeat count, period and level are captured at start, so later changes on those inputs do not affect the run. A start pulse during a run is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a run when idle |
| testMode | input | 2 | 0 quasi-static, 1 perturbated, 2 alternated, 3 treated as 0 |
| repeatCount | input | CNT_W | Number of full-scale sweeps (0 means 1) |
| pertPeriod | input | PER_W | Ramp steps between perturbations (0 disables) |
| pertLevel | input | DAC_W | Code used for perturbation levels |
| dacCode | output | DAC_W | Code for the DAC |
| sampleStrobe | output | 1 | Capture the converter output in this cycle |
| pertSample | output | 1 | The strobed sample is a perturbation level |
| seqDone | output | 1 | One-cycle end-of-run pulse |

## Verification
All outputs are decoded from registered state with no output register. The first run cycle therefore appears one edge after start is sampled: settle phase of code 0, then its strobe on the next edge. A perturbation period starts on the edge after the strobe that completes the counted step. seqDone appears one edge after the final strobe and drops on the following edge. The bench drives inputs and samples outputs on falling edges. It builds the expected stream one cycle at a time from the requirements and compares every cycle of each run against it, including the done cycle and the idle cycle after it. This makes any shift by a cycle visible.

// File: rtl/rampStimPkg.sv
package rampStimPkg;

  typedef enum logic [1:0] {
    MODE_QUASI   = 2'd0,
    MODE_PERTURB = 2'd1,
    MODE_ALTERN  = 2'd2,
    MODE_SPARE   = 2'd3
  } testMode_t;

  typedef enum logic [1:0] {
    SEL_ZERO = 2'd0,
    SEL_RAMP = 2'd1,
    SEL_PERT = 2'd2
  } codeSel_t;

  // strobes from the sequencing control to the code datapath
  typedef struct packed {
    logic     rampClear;
    logic     rampStep;
    logic     latchCfg;
    codeSel_t codeSel;
    logic     strobe;
    logic     pertFlag;
  } ctrlStrobes_t;

endpackage

// File: rtl/rampStimCtrl.sv
module rampStimCtrl
  import rampStimPkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PER_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [1:0]         modeIn,
  input  logic [CNT_W-1:0]   countIn,
  input  logic [PER_W-1:0]   perIn,
  input  logic               rampLast,
  output ctrlStrobes_t       ctrl,
  output logic               seqDone
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [PER_W-1:0] PER_ONE = PER_W'(1);

  logic             running;
  logic             phaseB;
  logic             pertSlot;
  logic             pendPert;
  logic [PER_W-1:0] stepCnt;
  logic [CNT_W-1:0] sweepsLeft;
  testMode_t        cfgMode;
  logic [PER_W-1:0] cfgPer;

  logic launch;
  logic rampEnd;
  logic lastStep;
  logic hitPeriod;

  assign launch    = start && !running;
  assign rampEnd   = running && phaseB && !pertSlot;
  assign lastStep  = rampEnd && rampLast && (sweepsLeft == CNT_ONE);
  assign hitPeriod = (cfgPer != '0) && ((stepCnt + PER_ONE) == cfgPer);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running    <= 1'b0;
      phaseB     <= 1'b0;
      pertSlot   <= 1'b0;
      pendPert   <= 1'b0;
      stepCnt    <= '0;
      sweepsLeft <= '0;
      cfgMode    <= MODE_QUASI;
      cfgPer     <= '0;
      seqDone    <= 1'b0;
    end else begin
      seqDone <= 1'b0;
      if (launch) begin
        running    <= 1'b1;
        phaseB     <= 1'b0;
        pertSlot   <= 1'b0;
        pendPert   <= 1'b0;
        stepCnt    <= '0;
        sweepsLeft <= (countIn == '0) ? CNT_ONE : countIn;
        cfgMode    <= testMode_t'(modeIn);
        cfgPer     <= perIn;
      end else if (running) begin
        if (!phaseB) begin
          phaseB <= 1'b1;
        end else if (pertSlot) begin
          pertSlot <= 1'b0;
          phaseB   <= 1'b0;
        end else begin
          if (cfgPer != '0) begin
            stepCnt <= hitPeriod ? '0 : stepCnt + PER_ONE;
          end
          phaseB <= 1'b0;
          if (lastStep) begin
            running  <= 1'b0;
            pendPert <= 1'b0;
            seqDone  <= 1'b1;
          end else begin
            if (rampLast) begin
              sweepsLeft <= sweepsLeft - CNT_ONE;
            end
            if (hitPeriod && cfgMode == MODE_ALTERN) begin
              pertSlot <= 1'b1;
              pendPert <= 1'b0;
            end else begin
              pendPert <= hitPeriod;
            end
          end
        end
      end
    end
  end

  always_comb begin
    ctrl.rampClear = launch;
    ctrl.latchCfg  = launch;
    ctrl.rampStep  = rampEnd && !lastStep;
    ctrl.strobe    = running && phaseB;
    ctrl.pertFlag  = running && phaseB && pertSlot;
    if (!running) begin
      ctrl.codeSel = SEL_ZERO;
    end else if (pertSlot) begin
      ctrl.codeSel = SEL_PERT;
    end else if (!phaseB && pendPert && cfgMode == MODE_PERTURB) begin
      ctrl.codeSel = SEL_PERT;
    end else begin
      ctrl.codeSel = SEL_RAMP;
    end
  end

  // R2: at most one strobe per two-cycle period
  assert_one_strobe_per_period_R2 : assert property (@(posedge clk) disable iff (!rstN)
    ctrl.strobe |=> !ctrl.strobe);

  // R8: done lasts exactly one cycle
  assert_done_single_R8 : assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> !seqDone);

  // R4: only alternated mode may flag a perturbation sample
  assert_no_pert_sample_R4 : assert property (@(posedge clk) disable iff (!rstN)
    (running && cfgMode != MODE_ALTERN) |-> !ctrl.pertFlag);

  // R3: a running sequence always has a sweep left
  assert_sweeps_nonzero_R3 : assert property (@(posedge clk) disable iff (!rstN)
    running |-> (sweepsLeft != '0));

  // R1: a launch is followed by a settle phase, never a strobe
  assert_launch_settles_R1 : assert property (@(posedge clk) disable iff (!rstN)
    launch |=> (running && !ctrl.strobe));

endmodule

// File: rtl/rampStimData.sv
module rampStimData
  import rampStimPkg::*;
#(
  parameter int DAC_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       ctrl,
  input  logic [DAC_W-1:0]   levelIn,
  output logic [DAC_W-1:0]   dacCode,
  output logic               rampLast,
  output logic               sampleStrobe,
  output logic               pertSample
);

  localparam logic [DAC_W-1:0] CODE_ONE = DAC_W'(1);

  logic [DAC_W-1:0] rampCode;
  logic [DAC_W-1:0] cfgLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rampCode <= '0;
      cfgLevel <= '0;
    end else begin
      if (ctrl.latchCfg) begin
        cfgLevel <= levelIn;
      end
      if (ctrl.rampClear) begin
        rampCode <= '0;
      end else if (ctrl.rampStep) begin
        rampCode <= rampCode + CODE_ONE;
      end
    end
  end

  assign rampLast = &rampCode;

  always_comb begin
    unique case (ctrl.codeSel)
      SEL_RAMP: dacCode = rampCode;
      SEL_PERT: dacCode = cfgLevel;
      default:  dacCode = '0;
    endcase
  end

  assign sampleStrobe = ctrl.strobe;
  assign pertSample   = ctrl.pertFlag;

  // R3: stepping off the top code wraps to zero
  assert_ramp_wrap_R3 : assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.rampStep && rampLast) |=> (rampCode == '0));

endmodule

// File: rtl/rampStimSeq.sv
module rampStimSeq
  import rampStimPkg::*;
#(
  parameter int DAC_W = 16,
  parameter int CNT_W = 8,
  parameter int PER_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [1:0]         testMode,
  input  logic [CNT_W-1:0]   repeatCount,
  input  logic [PER_W-1:0]   pertPeriod,
  input  logic [DAC_W-1:0]   pertLevel,
  output logic [DAC_W-1:0]   dacCode,
  output logic               sampleStrobe,
  output logic               pertSample,
  output logic               seqDone
);

  ctrlStrobes_t ctrl;
  logic         rampLast;

  rampStimCtrl #(
    .CNT_W(CNT_W),
    .PER_W(PER_W)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .modeIn   (testMode),
    .countIn  (repeatCount),
    .perIn    (pertPeriod),
    .rampLast (rampLast),
    .ctrl     (ctrl),
    .seqDone  (seqDone)
  );

  rampStimData #(
    .DAC_W(DAC_W)
  ) data_i (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .levelIn      (pertLevel),
    .dacCode      (dacCode),
    .rampLast     (rampLast),
    .sampleStrobe (sampleStrobe),
    .pertSample   (pertSample)
  );

endmodule

// File: tb/rampStimSeq_tb_top.sv
module rampStimSeq_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int W     = 4;
  localparam int STEPS = 1 << W;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   testMode = 2'd0;
  logic [7:0]   repeatCount = 8'd1;
  logic [7:0]   pertPeriod = 8'd0;
  logic [W-1:0] pertLevel = '0;
  logic [W-1:0] dacCode;
  logic         sampleStrobe;
  logic         pertSample;
  logic         seqDone;

  int checks = 0;
  int errors = 0;
  int cycIdx = 0;
  int pokeAt = -1;

  always #2.5 clk = ~clk;

  rampStimSeq #(.DAC_W(W), .CNT_W(8), .PER_W(8)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .testMode(testMode),
    .repeatCount(repeatCount), .pertPeriod(pertPeriod), .pertLevel(pertLevel),
    .dacCode(dacCode), .sampleStrobe(sampleStrobe), .pertSample(pertSample),
    .seqDone(seqDone)
  );

  task automatic expectCyc(input logic [W-1:0] c, input logic s, input logic f,
                           input logic d, input string req, input string scen);
    @(negedge clk);
    checks++;
    if (dacCode !== c || sampleStrobe !== s || pertSample !== f || seqDone !== d) begin
      errors++;
      $display("FAIL %s [%s] cyc %0d: got code=%0h strb=%b pf=%b done=%b exp code=%0h strb=%b pf=%b done=%b",
               req, scen, cycIdx, dacCode, sampleStrobe, pertSample, seqDone, c, s, f, d);
    end
    cycIdx++;
    start = (cycIdx == pokeAt);
  endtask

  // Runs one configuration and walks the expected stream cycle by cycle.
  task automatic runStream(input int mode, input int count, input int per,
                           input int level, input int poke, input bit scramble,
                           input string scen);
    int  nSw;
    int  cnt;
    bit  pend;
    testMode    = 2'(mode);
    repeatCount = 8'(count);
    pertPeriod  = 8'(per);
    pertLevel   = W'(level);
    cycIdx = 0;
    pokeAt = poke;
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    #1;
    start = 1'b0;
    if (scramble) begin // R9: later input changes must not matter
      testMode    = (mode == 2) ? 2'd1 : 2'd2;
      repeatCount = 8'd7;
      pertPeriod  = 8'd1;
      pertLevel   = ~W'(level);
    end
    nSw  = (count == 0) ? 1 : count;
    cnt  = 0;
    pend = 1'b0;
    for (int s = 0; s < nSw; s++) begin
      for (int v = 0; v < STEPS; v++) begin
        if (pend && mode == 2) begin
          expectCyc(W'(level), 1'b0, 1'b0, 1'b0, "R5", scen);
          expectCyc(W'(level), 1'b1, 1'b1, 1'b0, "R5", scen);
        end
        if (pend && mode == 1)
          expectCyc(W'(level), 1'b0, 1'b0, 1'b0, "R4", scen);
        else
          expectCyc(W'(v), 1'b0, 1'b0, 1'b0, (v == 0) ? "R3" : "R2", scen);
        expectCyc(W'(v), 1'b1, 1'b0, 1'b0, "R2", scen);
        pend = 1'b0;
        if (per != 0) begin
          cnt++;
          if (cnt == per) begin
            pend = 1'b1;
            cnt  = 0;
          end
        end
      end
    end
    expectCyc('0, 1'b0, 1'b0, 1'b1, "R8", scen);
    expectCyc('0, 1'b0, 1'b0, 1'b0, "R8", scen);
    pokeAt = -1;
  endtask

  task automatic testReset();
    for (int i = 0; i < 3; i++) expectCyc('0, 1'b0, 1'b0, 1'b0, "R1", "reset_idle");
  endtask

  task automatic testQuasi();
    runStream(0, 2, 3, 9, -1, 1'b0, "R7_quasi_two_sweeps_R3");
  endtask

  task automatic testSpareMode();
    runStream(3, 1, 2, 5, -1, 1'b0, "R7_spare_mode");
  endtask

  task automatic testPerturbated();
    runStream(1, 2, 3, 15, -1, 1'b0, "R4_perturbated_p3");
  endtask

  task automatic testPerturbatedEvery();
    runStream(1, 1, 1, 0, -1, 1'b0, "R4_perturbated_p1_dark");
  endtask

  task automatic testAlternated();
    runStream(2, 2, 5, 12, -1, 1'b0, "R5_alternated_p5");
  endtask

  task automatic testAlternatedEnd();
    runStream(2, 2, 4, 15, -1, 1'b0, "R6_alternated_p4_no_tail");
  endtask

  task automatic testDisabled();
    runStream(2, 1, 0, 15, -1, 1'b0, "R6_period_zero");
  endtask

  task automatic testZeroCount();
    runStream(0, 0, 0, 0, -1, 1'b0, "R3_count_zero");
  endtask

  task automatic testLatchAndBusyStart();
    runStream(1, 1, 2, 10, 7, 1'b1, "R9_latched_cfg_busy_start");
    runStream(2, 1, 3, 6, 12, 1'b1, "R9_alternated_latched");
  endtask

  initial begin : watchdog
    #400us;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish (got timeout, exp completion)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : mainSeq
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testQuasi();
    testSpareMode();
    testPerturbated();
    testPerturbatedEvery();
    testAlternated();
    testAlternatedEnd();
    testDisabled();
    testZeroCount();
    testLatchAndBusyStart();
    testReset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule